// File: doc/BRIEF.md
# Index and data port register adapter

This block gives a byte-wide processor bus access to a large indexed register file through only two bus locations. One location is the index port. A write to it stores a register number in a latch inside the adapter, and a read from it returns that stored number. The other location is the data port. A read or write there goes to the register-file entry that the latch currently selects. The register file sits behind a separate strobe interface. That interface has a one-cycle read strobe, a one-cycle write strobe, an index, write data, and read data that the register file registers.

Each port answers at two bus addresses: a low offset (0 or 1) and an alias placed at `ALIAS_BASE` (0x70 by default) plus the same offset. The `SWAP_ROLES` parameter sets which offset is the index port. Every bus request receives exactly one response on the following cycle. The response carries a ready pulse, an error flag and, for reads, the returned byte. A request that is not byte-wide, or that hits no known address, receives an error response and touches nothing.

Top module: `idx_port_bridge`

## Requirements
- R1: With `SWAP_ROLES`=0, addresses 0x00 and `ALIAS_BASE` (0x70) are the index port, and addresses 0x01 and `ALIAS_BASE`+1 (0x71) are the data port.
- R2: With `SWAP_ROLES`=1, the roles are exchanged: 0x01/0x71 are the index port and 0x00/0x70 are the data port.
- R3: A valid byte write to the index port loads `bus_wdata` into the index latch. It raises neither `rf_rd` nor `rf_wr`, and it answers with ready, no error and `bus_rdata`=0.
- R4: A valid byte read of the index port returns the current latched index on `bus_rdata` in the response cycle. It raises no register-file strobe.
- R5: A valid byte read of the data port raises `rf_rd` for exactly the request cycle, with `rf_idx` equal to the latched index. In the next cycle, `bus_rdata` carries `rf_rdata` together with ready.
- R6: A valid byte write of the data port raises `rf_wr` for exactly the request cycle, with `rf_idx` equal to the latched index and `rf_wdata` equal to `bus_wdata`.
- R7: Only `bus_size`=0 (one byte) is legal. Any other size is answered with ready and `bus_err`=1, raises no strobe, and leaves the index latch unchanged.
- R8: A request to an address other than the four listed in R1/R2 is answered with ready and `bus_err`=1, raises no strobe, and leaves the index latch unchanged.
- R9: While `rst_n` is low, `bus_ready` is 0. After reset the latched index is 0.
- R10: Every request cycle is followed by exactly one ready cycle, and a cycle without a request is followed by none. Requests may arrive back to back. An index write is used by a data access in the very next cycle. Writes and errors return `bus_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus request valid for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_size | input | 2 | Access size code, 0 = byte (the only legal value) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Response pulse, one cycle after a request |
| bus_err | output | 1 | Response is an error |
| rf_rd | output | 1 | Register-file read strobe |
| rf_wr | output | 1 | Register-file write strobe |
| rf_idx | output | IDX_W | Register-file entry selected by the latch |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | input | 8 | Register-file read data, one cycle after `rf_rd` |

## Verification
The embedded assertions check, on every cycle, the following: the one-to-one pairing of requests with ready pulses, that strobes never accompany an illegal size, that the latch holds still unless an index write is accepted, and that a register-file read always leads to a clean response. The address map, and how it flips under `SWAP_ROLES`, can only be shown by the bench's scenarios. The same holds for returning the latched index, for write-then-read data integrity through the register file, and for error responses that leave the index unchanged. The bench covers these by driving the same stimulus into both variants and comparing each one against a behavioural model on every clock.

// File: rtl/idx_port_bridge.sv
module idx_port_bridge #(
  parameter int ADDR_W = 8,
  parameter int IDX_W = 8,
  parameter bit SWAP_ROLES = 1'b0,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = ADDR_W'('h70)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_ready,
  output logic              bus_err,
  output logic              rf_rd,
  output logic              rf_wr,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [7:0]        rf_wdata,
  input  logic [7:0]        rf_rdata
);
  localparam logic [ADDR_W-1:0] OFS0 = '0;
  localparam logic [ADDR_W-1:0] OFS1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ALIAS1 = ALIAS_BASE + OFS1;

  logic hit0, hit1, idx_hit, dat_hit, size_ok, good, bad;
  logic idx_wr, idx_rd;
  logic [IDX_W-1:0] idx_q;
  logic rsp_v, rsp_err, rsp_rf;
  logic [7:0] rsp_hold;

  assign hit0 = (bus_addr == OFS0) || (bus_addr == ALIAS_BASE);
  assign hit1 = (bus_addr == OFS1) || (bus_addr == ALIAS1);

  generate
    if (SWAP_ROLES) begin : g_swapped
      assign idx_hit = hit1;
      assign dat_hit = hit0;
    end else begin : g_normal
      assign idx_hit = hit0;
      assign dat_hit = hit1;
    end
  endgenerate

  assign size_ok = (bus_size == 2'd0);
  assign good    = bus_req && size_ok;
  assign bad     = bus_req && (!size_ok || !(idx_hit || dat_hit));

  assign idx_wr = good && idx_hit && bus_we;
  assign idx_rd = good && idx_hit && !bus_we;
  assign rf_wr  = good && dat_hit && bus_we;
  assign rf_rd  = good && dat_hit && !bus_we;

  assign rf_idx   = idx_q;
  assign rf_wdata = bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      rsp_v    <= 1'b0;
      rsp_err  <= 1'b0;
      rsp_rf   <= 1'b0;
      rsp_hold <= '0;
    end else begin
      rsp_v    <= bus_req;
      rsp_err  <= bad;
      rsp_rf   <= rf_rd;
      rsp_hold <= idx_rd ? 8'(idx_q) : 8'h00;
      if (idx_wr) idx_q <= bus_wdata[IDX_W-1:0];
    end
  end

  assign bus_ready = rsp_v;
  assign bus_err   = rsp_err;
  assign bus_rdata = rsp_rf ? rf_rdata : rsp_hold;

  // R10: one response per request, none otherwise
  p_ready_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ready);
  p_no_spurious_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ready);
  // R7: strobes only for byte requests
  p_strobe_needs_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_rd || rf_wr) |-> (bus_req && bus_size == 2'd0));
  // R3 R8: latch moves only on an accepted index write
  p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(idx_q));
  // R5: a register-file read yields a clean response next cycle
  p_rd_response_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd |=> (bus_ready && !bus_err));
  // R9: no response while held in reset
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |=> !bus_ready);
endmodule

// File: tb/idx_port_bridge_test.sv
`timescale 1ns/100ps
module idx_port_bridge_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [1:0] size = '0;

  logic [7:0] rdata [2];
  logic       ready [2], err [2], rrd [2], rwr [2];
  logic [7:0] ridx [2], rwd [2], rrdata [2];

  idx_port_bridge #(.SWAP_ROLES(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_size(size), .bus_wdata(wdata), .bus_rdata(rdata[0]), .bus_ready(ready[0]),
    .bus_err(err[0]), .rf_rd(rrd[0]), .rf_wr(rwr[0]), .rf_idx(ridx[0]),
    .rf_wdata(rwd[0]), .rf_rdata(rrdata[0]));

  idx_port_bridge #(.SWAP_ROLES(1'b1)) uut_swap (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_size(size), .bus_wdata(wdata), .bus_rdata(rdata[1]), .bus_ready(ready[1]),
    .bus_err(err[1]), .rf_rd(rrd[1]), .rf_wr(rwr[1]), .rf_idx(ridx[1]),
    .rf_wdata(rwd[1]), .rf_rdata(rrdata[1]));

  // register-file stand-ins, driven by each design's strobes
  logic [7:0] sfile [2][256];
  always_ff @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rrd[k]) rrdata[k] <= sfile[k][ridx[k]];
      if (rwr[k]) sfile[k][ridx[k]] <= rwd[k];
    end
  end

  // behavioural model
  int mem_m [2][256];
  int idx_m [2];
  bit pv [2], perr [2];
  int prd [2];
  int checks = 0, failures = 0;
  int cycles = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit rq, bit w, int a, int sz, int d);
    @(negedge clk);
    req = rq; we = w; addr = 8'(a); size = 2'(sz); wdata = 8'(d);
    #0.5;
    for (int k = 0; k < 2; k++) begin
      string rt;
      bit h0, h1, ih, dh, ok, bd;
      rt = (k == 0) ? "R1" : "R2";
      chk(ready[k] == pv[k], $sformatf("%s R10 ready", rt), ready[k], pv[k]);
      if (pv[k]) begin
        chk(err[k] == perr[k], $sformatf("%s R7 R8 err", rt), err[k], perr[k]);
        chk(rdata[k] == 8'(prd[k]), $sformatf("%s R4 R5 R10 rdata", rt), rdata[k], prd[k]);
      end
      h0 = (a == 0) || (a == 'h70);
      h1 = (a == 1) || (a == 'h71);
      ih = k ? h1 : h0;
      dh = k ? h0 : h1;
      ok = rq && (sz == 0);
      bd = rq && ((sz != 0) || !(ih || dh));
      chk(rrd[k] == (ok && dh && !w), $sformatf("%s R5 R3 R7 R8 rf_rd", rt), rrd[k], ok && dh && !w);
      chk(rwr[k] == (ok && dh && w), $sformatf("%s R6 R3 R7 R8 rf_wr", rt), rwr[k], ok && dh && w);
      if (ok && dh) begin
        chk(ridx[k] == 8'(idx_m[k]), $sformatf("%s R5 R6 rf_idx", rt), ridx[k], idx_m[k]);
        if (w) chk(rwd[k] == 8'(d), $sformatf("%s R6 rf_wdata", rt), rwd[k], d);
      end
      pv[k] = rq;
      perr[k] = bd;
      prd[k] = (ok && ih && !w) ? idx_m[k] : (ok && dh && !w) ? mem_m[k][idx_m[k]] : 0;
      if (ok && ih && w) idx_m[k] = d & 'hff;
      if (ok && dh && w) mem_m[k][idx_m[k]] = d & 'hff;
    end
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog R10 actual=%0d expected=<100000", cycles);
      summary();
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      idx_m[k] = 0; pv[k] = 0; perr[k] = 0; prd[k] = 0;
      for (int i = 0; i < 256; i++) begin
        sfile[k][i] = 8'(i * 7 + 3);
        mem_m[k][i] = (i * 7 + 3) & 'hff;
      end
    end
    repeat (3) @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    chk(ready[0] == 1'b0, "R9 ready in reset", ready[0], 0);
    chk(ready[1] == 1'b0, "R9 ready in reset swap", ready[1], 0);
    req = 1'b0;
    rst_n = 1'b1;
    // R9: index reads 0 after reset (default instance, index port 0)
    cyc(1, 0, 'h00, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk(rdata[0] == 8'h00, "R9 reset index", rdata[0], 0);
    // R1 R2 R3 R5 R6: index then data, both aliases
    cyc(1, 1, 'h00, 0, 'h05);
    cyc(1, 0, 'h01, 0, 0);
    cyc(1, 1, 'h71, 0, 'hA5);
    cyc(1, 0, 'h01, 0, 0);
    cyc(1, 0, 'h70, 0, 0);
    cyc(1, 1, 'h71, 0, 'h3C);
    cyc(1, 1, 'h70, 0, 'h9E);
    cyc(1, 1, 'h01, 0, 'h44);
    cyc(1, 0, 'h71, 0, 0);
    cyc(1, 0, 'h00, 0, 0);
    cyc(0, 0, 0, 0, 0);
    // R7: illegal sizes leave index untouched
    cyc(1, 1, 'h00, 1, 'h77);
    cyc(1, 1, 'h01, 2, 'h66);
    cyc(1, 0, 'h70, 3, 0);
    cyc(1, 0, 'h00, 0, 0);
    cyc(1, 0, 'h01, 0, 0);
    // R8: unmapped addresses
    cyc(1, 1, 'h02, 0, 'h12);
    cyc(1, 1, 'h72, 0, 'h13);
    cyc(1, 0, 'hFF, 0, 0);
    cyc(1, 1, 'h6F, 0, 'h14);
    cyc(1, 0, 'h70, 0, 0);
    cyc(1, 0, 'h71, 0, 0);
    // R10: gaps and back-to-back with index boundary values
    cyc(1, 1, 'h00, 0, 'hFF);
    cyc(0, 0, 0, 0, 0);
    cyc(1, 1, 'h01, 0, 'h81);
    cyc(1, 0, 'h01, 0, 0);
    cyc(1, 1, 'h70, 0, 'h00);
    cyc(1, 0, 'h71, 0, 0);
    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      int sel, a;
      sel = $urandom_range(0, 9);
      a = (sel < 2) ? 0 : (sel < 4) ? 1 : (sel < 6) ? 'h70 : (sel < 8) ? 'h71 : $urandom_range(0, 255);
      cyc($urandom_range(0, 4) != 0, $urandom_range(0, 1), a,
          ($urandom_range(0, 7) == 0) ? $urandom_range(1, 3) : 0, $urandom_range(0, 255));
    end
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    summary();
  end
endmodule